// File: doc/BRIEF.md
# Loopback Codeword Persistence Detector

The detector takes a stream of far-end alarm and control codeword events that have already been extracted from the line. Each event names a channel and says whether the codeword was a loopback activate, a loopback deactivate or some other command. The block serves 28 low-rate tributary channels and one high-rate aggregate channel. For every channel it holds a loopback status bit. That bit changes only when the same loopback command has arrived four times in a row for that channel. A single stray or corrupted codeword therefore never switches a loopback.

Each channel also has a sticky change bit. It latches every transition of the status bit, in either direction. Software reads status and change bits through a small byte-wide register port. A mode input selects whether the change bits clear when their word is read, or when a 1 is written to them.

Top module: `loop_persist_det`

## Requirements
- R1: Four loopback-activate events in a row for one channel (type code 2'b01) set that channel's status bit. The bit is visible on the register port in the cycle after the fourth event.
- R2: Four loopback-deactivate events in a row for one channel (type code 2'b10) clear that channel's status bit.
- R3: The 29 channels are independent. Channel index 0 is the aggregate channel and indices 1 to 28 are the tributaries. Events for one channel neither advance nor break another channel's run, even when the events are interleaved.
- R4: A channel's change bit sets whenever its status bit goes from 0 to 1 or from 1 to 0.
- R5: In clear-on-read mode (`clr_mode` = 0), a read of a change word clears all bits of that word on the read cycle's clock edge. Writes then have no effect on the change bits. A cleared bit stays 0 until the next status transition.
- R6: After reset, every status bit and every change bit reads 0.
- R7: Register map. `addr[3]` = 0 selects status and 1 selects change. `addr[2:0]` values 0 to 3 select the tributary words, with channel 8w+b+1 in bit b of word w. Word 3 holds channels 25 to 28 in bits 3:0 and reads 0 in bits 7:4. Word 4 holds the aggregate channel in bit 0. Every other address and bit reads 0, and writes to status words have no effect.
- R8: Any event for a channel whose type differs from that channel's previous event restarts the run count at one. This includes an "other" event (type code 2'b00 or 2'b11).
- R9: In clear-on-write mode (`clr_mode` = 1), writing 1 to a change bit clears it and writing 0 leaves it unchanged. Reads do not clear.
- R10: Further identical loopback events after the status has already taken that value do not set the change bit again.
- R11: If a status transition and a clear of the same change bit fall in the same cycle, the change bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Codeword event strobe |
| ev_chan | input | 5 | Event channel: 0 aggregate, 1 to 28 tributary |
| ev_kind | input | 2 | 01 activate, 10 deactivate, 00/11 other |
| clr_mode | input | 1 | 0 clear-on-read, 1 clear-on-write |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |

## Verification
The assertions assume that events only name channels 0 to 28. Under that assumption at most one status bit can move in a cycle, and a status edge must follow a matching loopback event on the same channel. They also assume `clr_mode` is not switched while change bits are pending. The directed stimulus only drives valid channel indices and changes the mode only after every change word has been read clear. Each event is held for exactly one cycle, with idle gaps that leave run counts untouched.

// File: rtl/loop_persist_det.sv
module loop_persist_det #(
  parameter int N_TRIB = 28,
  parameter int RUN    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_valid,
  input  logic [4:0] ev_chan,
  input  logic [1:0] ev_kind,
  input  logic       clr_mode,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam int NCH = N_TRIB + 1;
  localparam int NW  = (N_TRIB + 7) / 8;
  localparam int CW  = (RUN > 2) ? $clog2(RUN) : 1;
  localparam logic [1:0] K_ACT = 2'b01, K_DEA = 2'b10, K_OTH = 2'b00, K_NONE = 2'b11;

  logic [NCH-1:0] stat_v, dlt_v;
  wire  [1:0] kind_n = (ev_kind == K_NONE) ? K_OTH : ev_kind;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int W = (i == 0) ? NW : (i - 1) / 8;
    localparam int B = (i == 0) ? 0 : (i - 1) % 8;
    logic [CW-1:0] cnt_q;
    logic [1:0]    last_q;
    logic          st_q, dl_q;

    wire hit  = ev_valid && (ev_chan == 5'(i));
    wire same = (kind_n == last_q);
    wire full = hit && same && (kind_n != K_OTH) && (32'(cnt_q) >= RUN - 2);
    wire flip = full && ((kind_n == K_ACT) != st_q);
    wire sel  = (addr == {1'b1, 3'(W)});
    wire clr  = clr_mode ? (wr_en && sel && wdata[B]) : (rd_en && sel);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q  <= '0;
        last_q <= K_NONE;
        st_q   <= 1'b0;
        dl_q   <= 1'b0;
      end else begin
        if (hit) begin
          last_q <= kind_n;
          if (!same)                          cnt_q <= '0;
          else if (32'(cnt_q) < RUN - 1)      cnt_q <= cnt_q + 1'b1;
        end
        if (flip) st_q <= ~st_q;
        dl_q <= flip | (dl_q & ~clr);
      end
    end

    assign stat_v[i] = st_q;
    assign dlt_v[i]  = dl_q;
  end

  always_comb begin
    rdata = '0;
    if (32'(addr[2:0]) == NW) begin
      rdata[0] = addr[3] ? dlt_v[0] : stat_v[0];
    end else if (32'(addr[2:0]) < NW) begin
      for (int b = 0; b < 8; b++) begin
        if (32'(addr[2:0]) * 8 + b + 1 <= N_TRIB)
          rdata[b] = addr[3] ? dlt_v[32'(addr[2:0]) * 8 + b + 1]
                             : stat_v[32'(addr[2:0]) * 8 + b + 1];
      end
    end
  end
endmodule

module loop_persist_det_chk #(
  parameter int NCH = 29
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ev_valid,
  input logic [4:0]     ev_chan,
  input logic [1:0]     ev_kind,
  input logic [3:0]     addr,
  input logic [7:0]     rdata,
  input logic [NCH-1:0] stat_v,
  input logic [NCH-1:0] dlt_v
);
  // R3: one event per cycle can move at most one status bit
  a_r3_single_move: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stat_v ^ $past(stat_v)) <= 1);

  // R7: unused high bits of the top tributary word read zero
  a_r7_top_word_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[2:0] == 3'd3) |-> (rdata[7:4] == 4'h0));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    a_r1_rise_on_act: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_v[i]) |-> $past(ev_valid && ev_chan == 5'(i) && ev_kind == 2'b01));
    a_r2_fall_on_deact: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_v[i]) |-> $past(ev_valid && ev_chan == 5'(i) && ev_kind == 2'b10));
    a_r4_delta_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_v[i] != $past(stat_v[i])) |-> dlt_v[i]);
    a_r10_no_spurious_delta: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dlt_v[i]) |-> (stat_v[i] != $past(stat_v[i])));
  end
endmodule

bind loop_persist_det loop_persist_det_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_chan(ev_chan),
  .ev_kind(ev_kind), .addr(addr), .rdata(rdata), .stat_v(stat_v), .dlt_v(dlt_v)
);

// File: tb/test_loop_persist_det.sv
module test_loop_persist_det;
  localparam int TCLK = 10;
  localparam logic [1:0] ACT = 2'b01, DEA = 2'b10, OTH = 2'b00;

  logic clk = 0, rst_n = 0, ev_valid = 0, clr_mode = 0, rd_en = 0, wr_en = 0;
  logic [4:0] ev_chan = 0;
  logic [1:0] ev_kind = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  int n_chk = 0, n_bad = 0;

  loop_persist_det i_loop_persist_det (.*);

  always #(TCLK/2) clk = ~clk;

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic send(int ch, logic [1:0] k, int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk); ev_valid = 1; ev_chan = 5'(ch); ev_kind = k;
      @(negedge clk); ev_valid = 0;
    end
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1; #1 v = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 16; a++) begin rd(4'(a), v); chk("R6 reset", v, 8'h00); end
  endtask

  task automatic t_activate();
    logic [7:0] v;
    send(5, ACT, 3); rd(0, v); chk("R1 three acts", v, 8'h00);
    send(5, ACT, 1); rd(0, v); chk("R1 fourth act", v, 8'h10);
    rd(8, v); chk("R4 rise delta", v, 8'h10);
    rd(8, v); chk("R5 cleared on read", v, 8'h00);
  endtask

  task automatic t_repeat();
    logic [7:0] v;
    send(5, ACT, 2); rd(0, v); chk("R10 status kept", v, 8'h10);
    rd(8, v); chk("R10 no new delta", v, 8'h00);
  endtask

  task automatic t_interrupt();
    logic [7:0] v;
    send(12, ACT, 3); send(12, OTH, 1); send(12, ACT, 3);
    rd(1, v); chk("R8 run restarted", v, 8'h00);
    send(12, ACT, 1); rd(1, v); chk("R8 run complete", v, 8'h08);
    rd(9, v); chk("R4 delta word1", v, 8'h08);
  endtask

  task automatic t_deact();
    logic [7:0] v;
    send(12, DEA, 3); rd(1, v); chk("R2 three deacts", v, 8'h08);
    send(12, DEA, 1); rd(1, v); chk("R2 fourth deact", v, 8'h00);
    rd(9, v); chk("R4 fall delta", v, 8'h08);
  endtask

  task automatic t_aggregate();
    logic [7:0] v;
    send(0, ACT, 4); rd(4, v); chk("R3 aggregate status", v, 8'h01);
    rd(0, v); chk("R3 tributaries untouched", v, 8'h10);
    rd(12, v); chk("R7 aggregate delta", v, 8'h01);
  endtask

  task automatic t_top_word();
    logic [7:0] v;
    send(28, ACT, 4); send(25, ACT, 4);
    rd(3, v); chk("R7 top word", v, 8'h09);
    rd(11, v); chk("R7 top delta", v, 8'h09);
    wr(0, 8'hFF); rd(0, v); chk("R7 status write ignored", v, 8'h10);
    wr(8, 8'hFF); rd(8, v); chk("R5 write no effect", v, 8'h00);
  endtask

  task automatic t_interleave();
    logic [7:0] v;
    for (int j = 0; j < 4; j++) begin send(1, ACT, 1); send(2, ACT, 1); end
    rd(0, v); chk("R3 interleaved", v, 8'h13);
    rd(8, v); chk("R3 interleaved delta", v, 8'h03);
  endtask

  task automatic t_cow();
    logic [7:0] v;
    clr_mode = 1;
    send(3, ACT, 4); rd(0, v); chk("R1 ch3", v, 8'h17);
    rd(8, v); chk("R9 delta set", v, 8'h04);
    rd(8, v); chk("R9 read keeps", v, 8'h04);
    wr(8, 8'hFB); rd(8, v); chk("R9 zero keeps", v, 8'h04);
    wr(8, 8'h04); rd(8, v); chk("R9 one clears", v, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    send(20, ACT, 3);
    @(negedge clk); ev_valid = 1; ev_chan = 20; ev_kind = ACT;
    addr = 10; wdata = 8'h08; wr_en = 1;
    @(negedge clk); ev_valid = 0; wr_en = 0;
    rd(10, v); chk("R11 set wins", v, 8'h08);
    wr(10, 8'h08); rd(10, v); chk("R9 later clear", v, 8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk); rst_n = 1;
        t_reset(); t_activate(); t_repeat(); t_interrupt(); t_deact();
        t_aggregate(); t_top_word(); t_interleave(); t_cow(); t_collide();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule